// File: doc/BRIEF.md
# LCD Backplane Generator with Slave Synchronisation

This block produces the square-wave common electrode (backplane) drive for a single-backplane LCD. It also produces 28 segment drive levels that are locked to that backplane. Each segment is phase-encoded. A dark segment follows the backplane exactly. A lit segment carries the inverse of the backplane. In either case the average voltage across the glass stays near zero.

In master mode, the block counts oscillator ticks in a 7-bit divider. The top bit of that divider is the backplane, so the backplane period is 128 ticks. The block drives this value on its backplane pin with the output enable asserted.

To enter slave mode, the oscillator pin is held low. The block then turns off its backplane driver, holds its divider at zero, and phases its segments against an external backplane input. Several devices can therefore share one master's backplane to build wider displays.

A run-length filter on the oscillator-pin level separates a deliberate hold-low from the normal low phases of an external clock. The same filter, with the same run length, decides the return to master mode.

Top module: `lcd_bp_drive`

## Requirements
- R1: A synchronous active-high reset clears the divider, selects master mode and drives every segment output to 0. While in reset and on the first cycle after it, the outputs are bp_out = 0, bp_oe = 1 and seg_out = 0.
- R2: In master mode the divider advances by one only on a clock edge where osc_tick is 1. bp_out equals bit 6 of the number of ticks counted since the divider was last cleared.
- R3: In master mode the backplane has a period of 128 ticks. bp_out is low for ticks 0 to 63 and high for ticks 64 to 127 of each period.
- R4: seg_out is registered. When seg_on[i] was 0 on the previous edge, seg_out[i] equals the backplane phase of that edge (bp_out in master, bp_in in slave).
- R5: When seg_on[i] was 1 on the previous edge, seg_out[i] is the inverse of that backplane phase.
- R6: The block enters slave mode after osc_level is sampled 0 on LOW_DETECT_CYCLES (default 16) consecutive edges. The mode changes on the last of those edges, and from then on bp_oe is 0.
- R7: A low run on osc_level shorter than LOW_DETECT_CYCLES samples leaves the mode unchanged. A single high sample restarts the count.
- R8: The block leaves slave mode only after osc_level is sampled 1 on LOW_DETECT_CYCLES consecutive edges. Shorter high runs leave it in slave mode.
- R9: In slave mode bp_out is 0, the divider is held at zero, and osc_tick has no effect.
- R10: After a return to master mode, the backplane restarts from the start of a period. bp_out stays low for the first 64 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, fast relative to the oscillator |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable for each oscillator period |
| osc_level | input | 1 | Sampled oscillator-pin level, used for mode sensing |
| bp_in | input | 1 | External backplane level, used in slave mode |
| seg_on | input | 28 | Segment-on vector, 1 = lit |
| bp_out | output | 1 | Backplane drive level |
| bp_oe | output | 1 | Backplane driver enable, 0 in slave mode |
| seg_out | output | 28 | Segment drive levels |

## Verification
The hardest case to reach from the ports is a low run on osc_level that stops exactly one sample short of the threshold, with the next low run then counted from zero. The stimulus builds runs of LOW_DETECT_CYCLES-1 low samples separated by single high samples. It then applies one run of full length, and later does the same with high runs while in slave mode. A second hard case is the divider restart after slave mode. To expose it, the bench keeps osc_tick active throughout slave mode and then follows a full backplane period after the return to master.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;

  typedef enum logic {
    MODE_MASTER = 1'b0,
    MODE_SLAVE  = 1'b1
  } bp_mode_e;

  // Level a segment drives: in phase when dark, inverted when lit.
  function automatic logic seg_level(input logic phase, input logic lit);
    return phase ^ lit;
  endfunction

  // True when the sampled pin level argues for leaving the current mode.
  function automatic logic level_opposes(input bp_mode_e mode, input logic lvl);
    return (mode == MODE_SLAVE) ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int DIV_BITS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  output logic phase
);
  logic [DIV_BITS-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || hold) count_q <= '0;
    else if (tick)   count_q <= count_q + 1'b1;
  end

  assign phase = count_q[DIV_BITS-1];

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hold) |=> $stable(count_q));
  p_slave_clear_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> (count_q == '0));
endmodule

// File: rtl/lcd_bp_mode_filter.sv
module lcd_bp_mode_filter
  import lcd_bp_pkg::*;
#(
  parameter int LOW_DETECT_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     osc_level,
  output bp_mode_e mode,
  output logic     mode_flip
);
  localparam int RUN_W = $clog2(LOW_DETECT_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOW_DETECT_CYCLES - 1);

  logic [RUN_W-1:0] run_q;
  logic             opposing;

  assign opposing  = level_opposes(mode, osc_level);
  assign mode_flip = opposing && (run_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_MASTER;
      run_q <= '0;
    end else if (mode_flip) begin
      mode  <= (mode == MODE_SLAVE) ? MODE_MASTER : MODE_SLAVE;
      run_q <= '0;
    end else if (opposing) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  p_enter_after_low_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MASTER) ##1 (mode == MODE_SLAVE) |-> $past(osc_level) == 1'b0);
  p_exit_after_high_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLAVE) ##1 (mode == MODE_MASTER) |-> $past(osc_level) == 1'b1);
  p_run_reset_r7: assert property (@(posedge clk) disable iff (rst)
    !opposing |=> (run_q == '0));
  p_run_bound_r7: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_LAST);
endmodule

// File: rtl/lcd_bp_segments.sv
module lcd_bp_segments
  import lcd_bp_pkg::*;
#(
  parameter int NUM_SEG = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               phase,
  input  logic [NUM_SEG-1:0] seg_on,
  output logic [NUM_SEG-1:0] seg_out
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) seg_out[i] <= 1'b0;
      else     seg_out[i] <= seg_level(phase, seg_on[i]);
    end
  end

  p_dark_in_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (seg_on == '0) |=> (seg_out == {NUM_SEG{$past(phase)}}));
  p_lit_inverted_r5: assert property (@(posedge clk) disable iff (rst)
    (seg_on == '1) |=> (seg_out == {NUM_SEG{~$past(phase)}}));
endmodule

// File: rtl/lcd_bp_drive.sv
module lcd_bp_drive
  import lcd_bp_pkg::*;
#(
  parameter int DIV_BITS          = 7,
  parameter int LOW_DETECT_CYCLES = 16,
  parameter int NUM_SEG           = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               osc_tick,
  input  logic               osc_level,
  input  logic               bp_in,
  input  logic [NUM_SEG-1:0] seg_on,
  output logic               bp_out,
  output logic               bp_oe,
  output logic [NUM_SEG-1:0] seg_out
);
  bp_mode_e mode;
  logic     mode_flip;
  logic     in_slave;
  logic     div_phase;
  logic     seg_phase;

  lcd_bp_mode_filter #(.LOW_DETECT_CYCLES(LOW_DETECT_CYCLES)) u_filter (
    .clk       (clk),
    .rst       (rst),
    .osc_level (osc_level),
    .mode      (mode),
    .mode_flip (mode_flip)
  );

  assign in_slave = (mode == MODE_SLAVE);

  lcd_bp_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk   (clk),
    .rst   (rst),
    .tick  (osc_tick),
    .hold  (in_slave),
    .phase (div_phase)
  );

  assign seg_phase = in_slave ? bp_in : div_phase;

  lcd_bp_segments #(.NUM_SEG(NUM_SEG)) u_seg (
    .clk     (clk),
    .rst     (rst),
    .phase   (seg_phase),
    .seg_on  (seg_on),
    .seg_out (seg_out)
  );

  assign bp_out = in_slave ? 1'b0 : div_phase;
  assign bp_oe  = ~in_slave;

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !bp_oe |-> !bp_out);
  p_oe_drops_on_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (bp_oe && mode_flip) |=> !bp_oe);
endmodule

// File: tb/sim_lcd_bp_drive.sv
`timescale 1ns/1ps
module sim_lcd_bp_drive;
  localparam int N   = 16;
  localparam int NS  = 28;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          osc_tick = 1'b0;
  logic          osc_level = 1'b1;
  logic          bp_in = 1'b0;
  logic [NS-1:0] seg_on = '0;
  logic          bp_out, bp_oe;
  logic [NS-1:0] seg_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Bench model state, derived from the requirements.
  int            m_ticks = 0;   // ticks since the divider was last cleared
  bit            m_slave = 1'b0;
  int            m_run   = 0;
  logic [NS-1:0] m_seg   = '0;

  always #4 clk = ~clk;

  lcd_bp_drive u0 (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .osc_level(osc_level),
    .bp_in(bp_in), .seg_on(seg_on), .bp_out(bp_out), .bp_oe(bp_oe),
    .seg_out(seg_out)
  );

  function automatic logic exp_bp();
    return m_slave ? 1'b0 : logic'((m_ticks / 64) % 2);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [NS-1:0] act, input logic [NS-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Advance one clock with the current inputs, update the model, compare outputs.
  task automatic cyc(input string req);
    logic ph;
    bit   opp;
    ph = m_slave ? bp_in : exp_bp();
    if (rst) begin
      m_ticks = 0; m_slave = 1'b0; m_run = 0; m_seg = '0;
    end else begin
      m_seg = seg_on ^ {NS{ph}};
      opp = m_slave ? (osc_level == 1'b1) : (osc_level == 1'b0);
      if (m_slave) m_ticks = 0;
      else if (osc_tick) m_ticks = (m_ticks + 1) % 128;
      if (opp) begin
        if (m_run == N - 1) begin m_slave = !m_slave; m_run = 0; end
        else m_run++;
      end else m_run = 0;
    end
    @(posedge clk);
    #1;
    chk(req, "bp_oe",   NS'(bp_oe),  NS'(!m_slave));
    chk(req, "bp_out",  NS'(bp_out), NS'(exp_bp()));
    chk(req, "seg_out", seg_out,     m_seg);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst = 1'b1; seg_on = '1;
    repeat (3) cyc("R1");
    rst = 1'b0;
    seg_on = '0; osc_tick = 1'b0;
    cyc("R1");

    // R2: no ticks, divider stands still
    repeat (20) cyc("R2");
    // R3: ticks every cycle for two full periods, dark segments
    osc_tick = 1'b1;
    repeat (260) cyc("R3");
    // R2: ticks every third cycle
    for (int k = 0; k < 300; k++) begin
      osc_tick = (k % 3 == 0);
      cyc("R2");
    end
    // R5: all lit across a period
    osc_tick = 1'b1; seg_on = '1;
    repeat (140) cyc("R5");
    // R4: walking-one and mixed patterns across both phases
    for (int b = 0; b < NS; b++) begin
      seg_on = NS'(1) << b;
      repeat (5) cyc("R4");
    end
    seg_on = 28'h5A5_C33C;
    repeat (80) cyc("R4");

    // R7: low runs one short of the threshold, separated by one high sample
    for (int r = 0; r < 3; r++) begin
      osc_level = 1'b0;
      repeat (N - 1) cyc("R7");
      osc_level = 1'b1;
      cyc("R7");
    end
    // R6: a full low run enters slave mode
    osc_level = 1'b0;
    repeat (N + 4) cyc("R6");

    // R9: slave mode with the external backplane toggling, ticks still active
    for (int b = 0; b < NS; b++) begin
      seg_on = (b % 2 == 0) ? ~(NS'(1) << b) : (NS'(1) << b);
      bp_in = 1'b0; cyc("R9");
      bp_in = 1'b1; cyc("R9");
      cyc("R9");
    end

    // R8: high runs one short keep slave; full run returns to master
    for (int r = 0; r < 2; r++) begin
      osc_level = 1'b1;
      repeat (N - 1) cyc("R8");
      osc_level = 1'b0;
      cyc("R8");
    end
    bp_in = 1'b1;
    osc_level = 1'b1;
    repeat (N) cyc("R8");

    // R10: backplane restarts from the start of a period
    seg_on = 28'h0F0_F0F0;
    repeat (200) cyc("R10");

    // R1: reset in mid-run
    rst = 1'b1;
    cyc("R1");
    rst = 1'b0; osc_tick = 1'b0;
    cyc("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule